// File: doc/BRIEF.md
# Extended State Enable Register

This block holds the control word that switches on optional groups of processor state for selective save and restore. Each of the lower 63 bits may stand for one state group. Bit 0 is the base floating-point and packed-integer group and is always on. Bit 1 is the vector register and vector control/status group. The top bit is reserved for good and never names a group. Software reads the current value on a read port. It changes the value through a write port that checks every write before committing it.

A write is checked against three things: the caller's privilege level, the mandatory bit 0, and the supported-group mask given on a configuration input. The block always treats the top bit as unsupported and bit 0 as supported, whatever that input says. If a write fails any check, the stored value stays as it was. The block then raises a one-cycle general-protection fault pulse with a cause code.

A save-request interface combines the register with a mask supplied by the caller. The result is the set of state groups that a selective save must cover.

Top module: `xstate_en_reg`

## Requirements
- R1: After reset `rd_data` reads 1 (only bit 0 set), and `fault` and `fault_cause` read 0.
- R2: A write with `wr_en`=1 that passes every check is committed at the next rising edge, and `rd_data` shows the new value from then on.
- R3: A write at privilege level 0 that clears bit 0 is not committed. In the cycle after it, `fault`=1 and `fault_cause`=0.
- R4: A write at privilege level 0 that keeps bit 0 set but sets bit 63 is not committed and faults with `fault_cause`=1. This holds even when `supp_mask` bit 63 is 1.
- R5: A write at privilege level 0 that keeps bit 0 set but sets any bit whose `supp_mask` bit is 0 faults with `fault_cause`=1 and is not committed. Bit 0 counts as supported even when `supp_mask` bit 0 is 0.
- R6: A write with `cpl` not equal to 0 is not committed and faults with `fault_cause`=2, whatever the data.
- R7: The cause priority is privilege (2), then bit 0 clear (0), then reserved or unsupported bit (1).
- R8: `fault` is high only in the single cycle that follows a faulting write. In every other cycle `fault` and `fault_cause` are 0.
- R9: `save_valid` equals `save_req`. `save_mask` equals `rd_data & save_req_mask` while `save_req`=1, and 0 otherwise. Both are combinational.
- R10: `rd_data` bit 0 is always 1 and bit 63 is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | 64 | Value proposed for the register |
| cpl | input | 2 | Current privilege level of the writer |
| supp_mask | input | 64 | State groups the implementation supports |
| rd_data | output | 64 | Current register value |
| fault | output | 1 | General-protection fault pulse |
| fault_cause | output | 2 | 0 bit 0 cleared, 1 reserved or unsupported bit, 2 privilege |
| save_req | input | 1 | Selective save request |
| save_req_mask | input | 64 | Caller's save mask |
| save_valid | output | 1 | Qualifies save_mask |
| save_mask | output | 64 | State groups to save |

## Verification
A behavioural model in the bench follows every write.

Writes of a legal value set different bits, to show that a legal commit really replaces the stored value rather than merging into it. Single-fault writes are each aimed at one check alone: bit 0 cleared, bit 63 set, an unsupported bit, and a nonzero privilege level. Combined-fault writes then show which cause code wins. A `supp_mask` with bit 0 clear and bit 63 set confirms that the block forces those two bits.

Save requests are issued with masks that overlap the register partly, fully and not at all, and with `save_req` low. Together these separate the AND from a pass-through of either operand.

// File: rtl/xstate_en_reg.sv
module xstate_en_reg #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   cpl,
  input  logic [W-1:0] supp_mask,
  output logic [W-1:0] rd_data,
  output logic         fault,
  output logic [1:0]   fault_cause,
  input  logic         save_req,
  input  logic [W-1:0] save_req_mask,
  output logic         save_valid,
  output logic [W-1:0] save_mask
);
  localparam int TOP = W - 1;
  localparam logic [W-1:0] BASE_BIT = W'(1);
  localparam logic [W-1:0] RSVD_BIT = W'(1) << TOP;
  localparam logic [1:0] C_BASE = 2'd0, C_RSVD = 2'd1, C_PRIV = 2'd2;

  logic [W-1:0] en_q;
  logic [W-1:0] legal;
  logic         bad_priv, bad_base, bad_rsvd, bad;
  logic [1:0]   cause_d;

  assign legal    = (supp_mask | BASE_BIT) & ~RSVD_BIT;
  assign bad_priv = cpl != 2'd0;
  assign bad_base = !wr_data[0];
  assign bad_rsvd = |(wr_data & ~legal);
  assign bad      = bad_priv | bad_base | bad_rsvd;
  assign cause_d  = bad_priv ? C_PRIV : (bad_base ? C_BASE : C_RSVD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= BASE_BIT;
      fault       <= 1'b0;
      fault_cause <= 2'd0;
    end else begin
      fault       <= wr_en && bad;
      fault_cause <= (wr_en && bad) ? cause_d : 2'd0;
      if (wr_en && !bad) en_q <= wr_data;
    end
  end

  assign rd_data    = en_q;
  assign save_valid = save_req;
  assign save_mask  = save_req ? (en_q & save_req_mask) : '0;

  AST_BASE_SET: assert property (@(posedge clk) disable iff (!rst_n) rd_data[0]); // R10
  AST_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) !rd_data[TOP]); // R10
  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) fault |-> rd_data == $past(rd_data)); // R3
  AST_PRIV_FAULT: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && cpl != 2'd0) |=> (fault && fault_cause == 2'd2)); // R6
  AST_COMMIT: assert property (@(posedge clk) disable iff (!rst_n) ($past(wr_en) && !fault) |-> rd_data == $past(wr_data)); // R2
  AST_PULSE: assert property (@(posedge clk) disable iff (!rst_n) !$past(wr_en) |-> (!fault && fault_cause == 2'd0)); // R8
  AST_SAVE_SUBSET: assert property (@(posedge clk) disable iff (!rst_n) (save_mask & ~rd_data) == '0); // R9
endmodule

// File: tb/test_xstate_en_reg.sv
`timescale 1ns/1ps
module test_xstate_en_reg;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, save_req = 0;
  logic [63:0] wr_data = '0, supp_mask = 64'h3, save_req_mask = '0;
  logic [1:0]  cpl = '0;
  logic [63:0] rd_data, save_mask;
  logic        fault, save_valid;
  logic [1:0]  fault_cause;
  int n_run = 0, n_fail = 0;
  logic [63:0] m_reg;
  logic        m_fault;
  logic [1:0]  m_cause;

  always #2.5 clk = ~clk;

  xstate_en_reg #(.W(64)) i_xstate_en_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .cpl(cpl),
    .supp_mask(supp_mask), .rd_data(rd_data), .fault(fault), .fault_cause(fault_cause),
    .save_req(save_req), .save_req_mask(save_req_mask), .save_valid(save_valid),
    .save_mask(save_mask));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic we, input logic [63:0] d, input logic [1:0] pl);
    logic [63:0] ok_bits;
    ok_bits = supp_mask;
    ok_bits[0] = 1'b1;
    ok_bits[63] = 1'b0;
    m_fault = 0; m_cause = 0;
    if (we) begin
      if (pl != 0) begin m_fault = 1; m_cause = 2; end
      else if (d[0] == 0) begin m_fault = 1; m_cause = 0; end
      else if ((d & ~ok_bits) != 0) begin m_fault = 1; m_cause = 1; end
      else m_reg = d;
    end
  endtask

  task automatic step(input logic we, input logic [63:0] d, input logic [1:0] pl,
                      input logic sr, input logic [63:0] sm, input string tag);
    logic [63:0] exp_save;
    wr_en = we; wr_data = d; cpl = pl; save_req = sr; save_req_mask = sm;
    #1;
    exp_save = sr ? (m_reg & sm) : 64'h0;
    chk(save_valid == sr, "R9 save_valid", {63'h0, save_valid}, {63'h0, sr});
    chk(save_mask == exp_save, "R9 save_mask", save_mask, exp_save);
    @(posedge clk);
    model(we, d, pl);
    @(negedge clk);
    wr_en = 0; save_req = 0;
    chk(rd_data == m_reg, {tag, " rd_data"}, rd_data, m_reg);
    chk(fault == m_fault, {tag, " R8 fault"}, {63'h0, fault}, {63'h0, m_fault});
    chk(fault_cause == m_cause, {tag, " R7 cause"}, {62'h0, fault_cause}, {62'h0, m_cause});
    chk(rd_data[0] && !rd_data[63], "R10 fixed bits", rd_data, m_reg);
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    m_reg = 64'h1; m_fault = 0; m_cause = 0;
    #12 @(negedge clk);
    chk(rd_data == 64'h1, "R1 reset value", rd_data, 64'h1);
    chk(!fault && fault_cause == 0, "R1 reset fault", {62'h0, fault, fault_cause[0]}, 64'h0);
    rst_n = 1;
    @(negedge clk);
    supp_mask = 64'hFF;
    step(1, 64'h3, 0, 0, 0, "R2 legal write");
    step(0, 64'h0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R9 full overlap");
    step(1, 64'h5, 0, 1, 64'h6, "R2 replace value");
    step(0, 64'h0, 0, 1, 64'h6, "R9 partial overlap");
    step(0, 64'h0, 0, 1, 64'h8, "R9 no overlap");
    step(0, 64'h0, 0, 0, 64'hF, "R9 no request");
    step(1, 64'h6, 0, 0, 0, "R3 clear bit0");
    step(0, 64'h0, 0, 0, 0, "R8 pulse ends");
    step(1, 64'h8000_0000_0000_0001, 0, 0, 0, "R4 bit63 set");
    supp_mask = 64'h8000_0000_0000_0002;
    step(1, 64'h8000_0000_0000_0001, 0, 0, 0, "R4 bit63 forced off");
    step(1, 64'h3, 0, 0, 0, "R5 bit0 forced on");
    step(1, 64'h5, 0, 0, 0, "R5 unsupported bit");
    step(1, 64'h3, 1, 0, 0, "R6 privilege 1");
    step(1, 64'h3, 3, 0, 0, "R6 privilege 3");
    step(1, 64'h0, 2, 0, 0, "R7 priv over base");
    step(1, 64'h4, 0, 0, 0, "R7 base over rsvd");
    step(1, 64'h1, 0, 1, 64'h3, "R2 shrink");
    step(1, 64'h6, 0, 0, 0, "R3 back-to-back 1");
    step(1, 64'h3, 0, 0, 0, "R8 fault then commit");
    for (int i = 0; i < 40; i++)
      step(1, {$urandom, $urandom}, 2'($urandom_range(0, 3) == 0 ? 1 : 0),
           1'($urandom), {$urandom, $urandom}, "R2 random");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule